// File: doc/BRIEF.md
# Parallel SAR Converter Sequencer

This block runs a 14-bit successive-approximation converter that has a byte-wide output bus. It drives the converter's active-low chip-select, its read/convert select line and its upper-byte select line, and it collects each result. A single-cycle start request runs one full sample. The converter powers up and tracks the input. It then holds and converts, and the sequencer waits for the active-low end-of-conversion flag. Finally it reads the upper and lower bytes and joins them into one 14-bit code, which comes out with a one-cycle valid strobe.

A mode input is sampled with each start request. It chooses whether the converter drops into low-power shutdown after the conversion or stays in standby. The sequencer remembers the mode of the previous sample. When the converter is waking from shutdown, or when the sequencer does not know its power state (after reset or after a timeout), it stretches the tracking phase to a long reference settling time. Every timing limit is a parameter counted in system clock cycles: pulse widths, data-valid delay, tracking time, wake-up time, conversion timeout, bus release time and the minimum sample period.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset and whenever busy_o is low, adc_cs_n_o is 1, adc_rdc_o is 0, adc_hbyte_o is 0, code_vld_o is 0, and timeout_o is 0 until a timeout occurs.
- R2: Each sample makes chip-select fall three times. At the first fall the read/convert line is 0. At the second fall it equals the mode sampled with the start (1 = shutdown, 0 = standby). At the third fall it is 1. The line does not change while chip-select is low.
- R3: Every low phase and every high phase of chip-select between the first and last fall of a sample lasts at least T_CSW cycles.
- R4: The gap from the first to the second chip-select fall is exactly T_ACQ cycles when the previous sample ended in standby. It is exactly T_WAKE cycles after reset, after a shutdown sample, or after a timeout.
- R5: The third fall happens only after end-of-conversion has gone low. The upper byte is taken with adc_hbyte_o = 1, T_DATA cycles after the fall, and only its bits 5:0 are used. The lower byte is then taken with adc_hbyte_o = 0, T_DATA cycles later. The code is {upper[5:0], lower[7:0]}.
- R6: Each completed sample gives exactly one code_vld_o pulse, one cycle wide, with the code on code_o.
- R7: If end-of-conversion stays high for T_CONV cycles after the second chip-select phase, timeout_o rises and stays high. No valid pulse is given, chip-select returns high, and the next start request clears timeout_o.
- R8: busy_o rises the cycle after an accepted start and stays high until the sequencer is idle again. A start request seen while busy_o is high is ignored.
- R9: Two consecutive first chip-select falls are at least T_PERIOD cycles apart, and chip-select stays high at least T_BR cycles after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one sample (taken when idle) |
| pwr_off_i | input | 1 | Mode for this sample: 1 shutdown, 0 standby |
| adc_eoc_n_i | input | 1 | Converter end-of-conversion, active low |
| adc_data_i | input | 8 | Converter byte bus |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_rdc_o | output | 1 | Converter read/convert select |
| adc_hbyte_o | output | 1 | Converter upper-byte select |
| busy_o | output | 1 | Sample in progress |
| code_o | output | 14 | Last collected code |
| code_vld_o | output | 1 | One-cycle strobe for code_o |
| timeout_o | output | 1 | Sticky conversion timeout flag |

## Verification
The bench goes after the wake-up decision across the full mode history: first sample after reset, standby followed by shutdown, shutdown followed by standby, and the sample after a timeout. A design that tracked the mode wrongly would give the short tracking time when the long one is due, or the reverse, and the measured gap between the first two falls would be off. A converter model that never lowers end-of-conversion checks the timeout path. A broken design would hang busy, give a stale valid pulse, or keep the flag set through the next start. The model also puts ones in the two spare upper-byte bits, sends a second start while busy, and flips the mode input right after the start. Each of these catches a design that fails to mask the spare bits, restarts on the extra request, or samples the mode late.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int T_CSW    = 5,
  parameter int T_DATA   = 10,
  parameter int T_ACQ    = 250,
  parameter int T_WAKE   = 1500000,
  parameter int T_CONV   = 600,
  parameter int T_BR     = 10,
  parameter int T_PERIOD = 926
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        pwr_off_i,
  input  logic        adc_eoc_n_i,
  input  logic [7:0]  adc_data_i,
  output logic        adc_cs_n_o,
  output logic        adc_rdc_o,
  output logic        adc_hbyte_o,
  output logic        busy_o,
  output logic [13:0] code_o,
  output logic        code_vld_o,
  output logic        timeout_o
);
  localparam int CW = $clog2(T_WAKE + T_CONV + T_ACQ + T_PERIOD + 1);
  localparam int PW = $clog2(T_PERIOD + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ACQ_LO, S_ACQ_HI, S_CNV_LO, S_CNV_HI, S_RD_HI, S_RD_LO, S_REL
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pc;
  logic [1:0]    eoc_sy;
  logic          mode, asleep;
  logic [5:0]    hi;

  wire eoc_s   = eoc_sy[1];
  wire cnt_end = (cnt == '0);

  assign busy_o = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; pc <= '0; eoc_sy <= 2'b11;
      mode <= 1'b0; asleep <= 1'b1; hi <= '0;
      adc_cs_n_o <= 1'b1; adc_rdc_o <= 1'b0; adc_hbyte_o <= 1'b0;
      code_o <= '0; code_vld_o <= 1'b0; timeout_o <= 1'b0;
    end else begin
      eoc_sy <= {eoc_sy[0], adc_eoc_n_i};
      code_vld_o <= 1'b0;
      if (pc != PW'(T_PERIOD)) pc <= pc + 1'b1;
      case (st)
        S_IDLE: if (start_i) begin
          timeout_o <= 1'b0;
          mode <= pwr_off_i;
          cnt <= CW'(T_CSW - 1);
          st <= S_SETUP;
        end
        S_SETUP: if (cnt_end) begin
          adc_cs_n_o <= 1'b0; pc <= '0;
          cnt <= CW'(T_CSW - 1);
          st <= S_ACQ_LO;
        end else cnt <= cnt - 1'b1;
        S_ACQ_LO: if (cnt_end) begin
          adc_cs_n_o <= 1'b1; adc_rdc_o <= mode;
          cnt <= asleep ? CW'(T_WAKE - T_CSW - 1) : CW'(T_ACQ - T_CSW - 1);
          st <= S_ACQ_HI;
        end else cnt <= cnt - 1'b1;
        S_ACQ_HI: if (cnt_end) begin
          adc_cs_n_o <= 1'b0;
          cnt <= CW'(T_CSW - 1);
          st <= S_CNV_LO;
        end else cnt <= cnt - 1'b1;
        S_CNV_LO: if (cnt_end) begin
          adc_cs_n_o <= 1'b1; adc_rdc_o <= 1'b1;
          cnt <= CW'(T_CONV - 1);
          st <= S_CNV_HI;
        end else cnt <= cnt - 1'b1;
        S_CNV_HI: if (!eoc_s && cnt <= CW'(T_CONV - T_CSW)) begin
          adc_cs_n_o <= 1'b0; adc_hbyte_o <= 1'b1;
          cnt <= CW'(T_DATA - 1);
          st <= S_RD_HI;
        end else if (cnt_end) begin
          timeout_o <= 1'b1; asleep <= 1'b1; adc_rdc_o <= 1'b0;
          cnt <= CW'(T_BR - 1);
          st <= S_REL;
        end else cnt <= cnt - 1'b1;
        S_RD_HI: if (cnt_end) begin
          hi <= adc_data_i[5:0]; adc_hbyte_o <= 1'b0;
          cnt <= CW'(T_DATA - 1);
          st <= S_RD_LO;
        end else cnt <= cnt - 1'b1;
        S_RD_LO: if (cnt_end) begin
          code_o <= {hi, adc_data_i}; code_vld_o <= 1'b1;
          adc_cs_n_o <= 1'b1; adc_rdc_o <= 1'b0; asleep <= mode;
          cnt <= CW'(T_BR - 1);
          st <= S_REL;
        end else cnt <= cnt - 1'b1;
        S_REL: if (!cnt_end) cnt <= cnt - 1'b1;
          else if (pc == PW'(T_PERIOD)) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic adc_cs_n_o,
  input logic adc_rdc_o,
  input logic adc_hbyte_o,
  input logic busy_o,
  input logic code_vld_o,
  input logic timeout_o
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (adc_cs_n_o && !adc_hbyte_o && !code_vld_o));
  a_r2_rdc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n_o && !$past(adc_cs_n_o)) |-> $stable(adc_rdc_o));
  a_r5_hbyte_read: assert property (@(posedge clk) disable iff (!rst_n)
    adc_hbyte_o |-> (!adc_cs_n_o && adc_rdc_o));
  a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_o |=> !code_vld_o);
  a_r7_tmo_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !code_vld_o);
  a_r8_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !timeout_o));
  a_r8_vld_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_o |-> busy_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (.*);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int T_CSW = 3, T_DATA = 4, T_ACQ = 20, T_WAKE = 200;
  localparam int T_CONV = 60, T_BR = 5, T_PERIOD = 120, CONV_LAT = 30;

  logic clk = 0, rst_n = 0, start = 0, pwr_off = 0, eoc_n = 1;
  logic [7:0] data;
  logic cs_n, rdc, hb, busy, vld, tmo;
  logic [13:0] code;

  adc_seq_ctrl #(.T_CSW(T_CSW), .T_DATA(T_DATA), .T_ACQ(T_ACQ), .T_WAKE(T_WAKE),
    .T_CONV(T_CONV), .T_BR(T_BR), .T_PERIOD(T_PERIOD)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pwr_off_i(pwr_off),
    .adc_eoc_n_i(eoc_n), .adc_data_i(data), .adc_cs_n_o(cs_n), .adc_rdc_o(rdc),
    .adc_hbyte_o(hb), .busy_o(busy), .code_o(code), .code_vld_o(vld), .timeout_o(tmo));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic [13:0] samp_q[$], exp_q[$];
  logic [13:0] cur = '0;
  bit out_en = 0, hang = 0, exp_mode = 0, asleep_exp = 1, prev_cs = 1;
  int t = 0, t_first = -1, t_rise = -1000, t_fall = 0, ph = 0, conv_left = 0, n_vld = 0;

  assign data = out_en ? (hb ? {2'b11, cur[13:8]} : cur[7:0]) : 8'h5A;

  // converter model
  always @(negedge clk) if (rst_n) begin
    t++;
    if (prev_cs && !cs_n) begin
      if (t_rise > -1000) chk(t - t_rise >= T_CSW, "R3", "cs high width", t - t_rise, T_CSW);
      if (ph == 0) begin
        chk(rdc == 1'b0, "R2", "rdc at first fall", rdc, 0);
        if (t_first >= 0) chk(t - t_first >= T_PERIOD, "R9", "sample period", t - t_first, T_PERIOD);
        t_first = t; eoc_n = 1; ph = 1;
      end else if (ph == 1) begin
        chk(rdc == exp_mode, "R2", "rdc at second fall", rdc, exp_mode);
        chk(t - t_first == (asleep_exp ? T_WAKE : T_ACQ), "R4", "tracking gap",
            t - t_first, asleep_exp ? T_WAKE : T_ACQ);
        cur = samp_q.pop_front();
        conv_left = hang ? -1 : CONV_LAT; ph = 2;
      end else begin
        chk(rdc == 1'b1, "R2", "rdc at third fall", rdc, 1);
        chk(eoc_n == 1'b0, "R5", "read before eoc", eoc_n, 0);
        out_en = 1; ph = 0;
      end
      t_fall = t;
    end
    if (!prev_cs && cs_n) begin
      chk(t - t_fall >= T_CSW, "R3", "cs low width", t - t_fall, T_CSW);
      t_rise = t; out_en = 0;
    end
    if (conv_left > 0) begin
      conv_left--;
      if (conv_left == 0) eoc_n = 0;
    end
    prev_cs = cs_n;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && vld) begin
    n_vld++;
    if (exp_q.size() == 0) chk(0, "R6", "unexpected valid", code, 0);
    else begin
      logic [13:0] e;
      e = exp_q.pop_front();
      chk(code == e, "R5", "code", code, e);
    end
  end

  task automatic conv(logic [13:0] v, bit m, bit hg, bit dbl);
    int v0;
    samp_q.push_back(v);
    if (!hg) exp_q.push_back(v);
    exp_mode = m; hang = hg; v0 = n_vld;
    @(negedge clk); pwr_off = m; start = 1;
    @(negedge clk); start = 0; pwr_off = ~m;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    chk(tmo == 1'b0, "R7", "timeout cleared by start", tmo, 0);
    if (dbl) begin
      repeat (10) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (busy) @(negedge clk);
    chk(n_vld - v0 == (hg ? 0 : 1), hg ? "R7" : "R6", "valid count", n_vld - v0, hg ? 0 : 1);
    chk(tmo == hg, "R7", "timeout flag", tmo, hg);
    if (hg) begin ph = 0; asleep_exp = 1; end else asleep_exp = m;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8", "no restart from ignored start", busy, 0);
    chk(cs_n == 1'b1 && rdc == 1'b0, "R1", "idle bus lines", {cs_n, rdc}, 2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 1 && rdc == 0 && hb == 0, "R1", "reset bus lines", {cs_n, rdc, hb}, 4);
    chk(busy == 0 && vld == 0 && tmo == 0, "R1", "reset status", {busy, vld, tmo}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    conv(14'h1555, 0, 0, 0);  // after reset: wake gap
    conv(14'h0000, 0, 0, 0);  // standby: short gap
    conv(14'h3FFF, 1, 0, 0);  // shutdown selected
    conv(14'h2000, 0, 0, 0);  // after shutdown: wake gap
    conv(14'h2AAA, 0, 1, 0);  // eoc never falls: timeout
    conv(14'h0101, 0, 0, 0);  // after timeout: wake gap, flag cleared
    conv(14'h1234, 0, 0, 1);  // extra start while busy ignored
    chk(exp_q.size() == 0, "R6", "results outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule